// File: doc/BRIEF.md
# UART Receive FIFO Interrupt Controller

This block decides which receive-side interrupt a FIFO-buffered UART raises, and when. It does not hold the received bytes. It watches the FIFO occupancy that the buffer reports, the push strobe from the deserialiser, the pop strobe from CPU reads, the pending line-error flags and a one-per-bit baud tick. From these it produces an interrupt request, a 4-bit identification code and a data-ready status bit.

There are three interrupt sources:
- **Trigger level.** Raised when occupancy reaches a selectable threshold.
- **Stale data.** Raised when characters sit unread. The wait is four character times, and the character length comes from the configured frame: data bits, parity and stop bits.
- **Line status.** Raised for a pending receive error. It outranks the other two.

The identification code and the request are registered, so a change at the inputs shows at the outputs one clock later. Data-ready follows the same one-cycle latency.

Top module: `uart_rx_irq_ctrl`

## Requirements
- R1: The trigger-level and stale-data codes are produced only while both `fifo_en` and `rx_data_ie` are 1. With either one at 0, and no line-status condition, `irq_id` reads 4'h1.
- R2: `trig_sel` selects the threshold: 0 gives 1 entry, 1 gives 4, 2 gives 8 and 3 gives 14 (depth 16). The cycle after `fifo_count` is at or above the threshold, `irq_id` is 4'h4. The cycle after it falls below, that code is gone.
- R3: While `line_stat_ie` is 1 and any bit of `err_flags` is set, `irq_id` is 4'h6 one cycle later, whatever the other sources are doing.
- R4: `data_ready` is 0 after reset and is 1 the cycle after an `rx_push`. It returns to 0 the cycle after `fifo_count` is seen as 0 with no push.
- R5: The stale-data timer limit is 4 × (1 + (5 + `data_sel`) + `parity_en` + 1 + `two_stop`) baud ticks. The timer counts while the FIFO holds data. When the limit-th tick since the last restart arrives, the stale-data flag is set, and `irq_id` reads 4'hC on the following cycle.
- R6: An `rx_pop` clears a raised stale-data flag and restarts the timer from zero.
- R7: An `rx_push` restarts the timer only while the stale-data flag is clear. A push after the flag has fired leaves 4'hC in place.
- R8: An empty FIFO clears the stale-data flag and holds the timer at zero. Baud ticks with `fifo_count` at 0 never produce 4'hC.
- R9: The trigger-level and stale-data sources share a rank. When both are pending, the code is 4'h4.
- R10: `irq` is 1 exactly when `irq_id` differs from 4'h1 (no receive interrupt pending).
- R11: After reset, `irq_id` is 4'h1, `irq` is 0 and `data_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | FIFO mode enable |
| rx_data_ie | input | 1 | Receive data interrupt enable |
| line_stat_ie | input | 1 | Line status interrupt enable |
| fifo_count | input | 5 | Current receive FIFO occupancy, 0 to 16 |
| rx_push | input | 1 | A character entered the FIFO this cycle |
| rx_pop | input | 1 | The CPU read one character this cycle |
| err_flags | input | 4 | Pending receive error conditions |
| trig_sel | input | 2 | Trigger threshold select |
| data_sel | input | 2 | Data bits minus five |
| parity_en | input | 1 | Parity bit present in the frame |
| two_stop | input | 1 | Second stop bit present in the frame |
| baud_tick | input | 1 | One pulse per bit time |
| irq | output | 1 | Receive interrupt request |
| irq_id | output | 4 | Receive interrupt code: 1 none, 6 line status, 4 threshold, C stale data |
| data_ready | output | 1 | Receive data ready status |

## Verification
The hardest state to reach from the ports is a stale-data flag that fires exactly on the limit-th tick for every frame shape. Off-by-one timing hides inside the restart rules.

The bench steps through all sixteen combinations of data length, parity and stop bits. For each one it issues exactly one tick fewer than the computed limit and confirms silence, then issues one more tick and expects 4'hC.

A separate sequence places a second push partway through the count. It then pushes after the flag has fired and pops to restart, which separates the restart rule that applies while the flag is clear from the one that applies after it has fired.

// File: rtl/rx_irq_pkg.sv
package rx_irq_pkg;

   // Receive-side identification codes; bit 0 set means nothing pending.
   typedef enum logic [3:0] {
      RXID_NONE   = 4'h1,
      RXID_LSTAT  = 4'h6,
      RXID_THRESH = 4'h4,
      RXID_STALE  = 4'hC
   } rx_id_e;

   // Threshold table for a power-of-two depth: 1, depth/4, depth/2, depth-2.
   function automatic int unsigned thresh_of(input logic [1:0] sel, input int unsigned depth);
      case (sel)
         2'd0:    return 1;
         2'd1:    return depth / 4;
         2'd2:    return depth / 2;
         default: return depth - 2;
      endcase
   endfunction

endpackage

// File: rtl/rx_trig_cmp.sv
module rx_trig_cmp
   import rx_irq_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic [CNT_W-1:0] fifo_count,
   input  logic [1:0]       trig_sel,
   output logic             reached
);

   logic [CNT_W-1:0] level;

   always_comb begin
      case (trig_sel)
         2'd0:    level = CNT_W'(thresh_of(2'd0, DEPTH));
         2'd1:    level = CNT_W'(thresh_of(2'd1, DEPTH));
         2'd2:    level = CNT_W'(thresh_of(2'd2, DEPTH));
         default: level = CNT_W'(thresh_of(2'd3, DEPTH));
      endcase
   end

   assign reached = (fifo_count >= level);

   // R2: every selectable threshold lies inside the FIFO
   always_comb begin
      assert_level_range_R2: assert (level != '0 && level <= CNT_W'(DEPTH))
         else $error("threshold out of range");
   end

endmodule

// File: rtl/rx_char_timeout.sv
module rx_char_timeout #(
   parameter int unsigned DEPTH     = 16,
   parameter int unsigned CHAR_MULT = 4,
   parameter int unsigned MIN_DATA  = 5,
   parameter int unsigned DSEL_W    = 2,
   localparam int unsigned CNT_W    = $clog2(DEPTH + 1),
   localparam int unsigned MAX_BITS = MIN_DATA + (1 << DSEL_W) + 3,
   localparam int unsigned MAX_LIM  = MAX_BITS * CHAR_MULT,
   localparam int unsigned TMR_W    = $clog2(MAX_LIM + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  fifo_count,
   input  logic              push,
   input  logic              pop,
   input  logic              baud_tick,
   input  logic [DSEL_W-1:0] data_sel,
   input  logic              parity_en,
   input  logic              two_stop,
   output logic              stale
);

   if (CHAR_MULT < 1) begin : g_bad_mult
      $error("CHAR_MULT must be at least 1");
   end
   if (MIN_DATA < 1) begin : g_bad_data
      $error("MIN_DATA must be at least 1");
   end

   logic [TMR_W-1:0] bits_per_char;
   logic [TMR_W-1:0] limit;
   logic [TMR_W-1:0] cnt_q;
   logic             fired_q;
   logic             nonempty;
   logic             at_limit;

   // start + data + parity + first stop + optional second stop
   assign bits_per_char = TMR_W'(MIN_DATA + 2) + TMR_W'(data_sel)
                        + TMR_W'(parity_en) + TMR_W'(two_stop);
   assign limit    = bits_per_char * TMR_W'(CHAR_MULT);
   assign nonempty = (fifo_count != '0);
   assign at_limit = (cnt_q == limit - TMR_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         fired_q <= 1'b0;
      end else if (pop || !nonempty) begin
         cnt_q   <= '0;
         fired_q <= 1'b0;
      end else if (push) begin
         if (!fired_q) cnt_q <= '0;
      end else if (baud_tick && !fired_q) begin
         if (at_limit) begin
            cnt_q   <= '0;
            fired_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + TMR_W'(1);
         end
      end
   end

   assign stale = fired_q;

   // R8: an empty FIFO leaves no stale flag behind
   assert_empty_cancels_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_count == '0) |=> !fired_q);

   // R6: a CPU read always clears the flag
   assert_pop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> !fired_q);

   // R7: a new character does not withdraw a fired flag
   assert_push_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fired_q && push && !pop && nonempty) |=> fired_q);

   // R5: the flag only rises on a baud tick
   assert_fire_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fired_q) |-> $past(baud_tick));

endmodule

// File: rtl/rx_irq_prio.sv
module rx_irq_prio
   import rx_irq_pkg::*;
(
   input  logic   lstat,
   input  logic   thresh,
   input  logic   stale,
   output rx_id_e code,
   output logic   any
);

   always_comb begin
      if (lstat)       code = RXID_LSTAT;
      else if (thresh) code = RXID_THRESH;
      else if (stale)  code = RXID_STALE;
      else             code = RXID_NONE;
   end

   assign any = lstat | thresh | stale;

   always_comb begin
      assert_code_legal_R10: assert (any == (code != RXID_NONE))
         else $error("request and code disagree");
   end

endmodule

// File: rtl/uart_rx_irq_ctrl.sv
module uart_rx_irq_ctrl
   import rx_irq_pkg::*;
#(
   parameter int unsigned DEPTH     = 16,
   parameter int unsigned CHAR_MULT = 4,
   parameter int unsigned MIN_DATA  = 5,
   parameter int unsigned DSEL_W    = 2,
   parameter int unsigned ERR_W     = 4,
   parameter bit          REG_OUT   = 1'b1,
   localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_en,
   input  logic              rx_data_ie,
   input  logic              line_stat_ie,
   input  logic [CNT_W-1:0]  fifo_count,
   input  logic              rx_push,
   input  logic              rx_pop,
   input  logic [ERR_W-1:0]  err_flags,
   input  logic [1:0]        trig_sel,
   input  logic [DSEL_W-1:0] data_sel,
   input  logic              parity_en,
   input  logic              two_stop,
   input  logic              baud_tick,
   output logic              irq,
   output logic [3:0]        irq_id,
   output logic              data_ready
);

   if (DEPTH < 8 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 8");
   end
   if (ERR_W < 1) begin : g_bad_err
      $error("ERR_W must be at least 1");
   end

   logic   rx_en;
   logic   reached;
   logic   stale;
   logic   lstat_c;
   logic   thresh_c;
   logic   stale_c;
   logic   any_c;
   rx_id_e code_c;
   logic   dr_q;

   assign rx_en    = fifo_en & rx_data_ie;
   assign lstat_c  = line_stat_ie & (|err_flags);
   assign thresh_c = rx_en & reached;
   assign stale_c  = rx_en & stale;

   rx_trig_cmp #(.DEPTH(DEPTH)) u_cmp (
      .fifo_count (fifo_count),
      .trig_sel   (trig_sel),
      .reached    (reached)
   );

   rx_char_timeout #(
      .DEPTH     (DEPTH),
      .CHAR_MULT (CHAR_MULT),
      .MIN_DATA  (MIN_DATA),
      .DSEL_W    (DSEL_W)
   ) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .fifo_count (fifo_count),
      .push       (rx_push),
      .pop        (rx_pop),
      .baud_tick  (baud_tick),
      .data_sel   (data_sel),
      .parity_en  (parity_en),
      .two_stop   (two_stop),
      .stale      (stale)
   );

   rx_irq_prio u_prio (
      .lstat  (lstat_c),
      .thresh (thresh_c),
      .stale  (stale_c),
      .code   (code_c),
      .any    (any_c)
   );

   // Data-ready: set by an arriving character, dropped once the FIFO reads empty.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dr_q <= 1'b0;
      else        dr_q <= rx_push | (dr_q & (fifo_count != '0));
   end
   assign data_ready = dr_q;

   assert_dr_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |=> data_ready);

   assert_dr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_count == '0 && !rx_push) |=> !data_ready);

   if (REG_OUT) begin : g_reg_out
      logic [3:0] id_q;
      logic       irq_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            id_q  <= RXID_NONE;
            irq_q <= 1'b0;
         end else begin
            id_q  <= code_c;
            irq_q <= any_c;
         end
      end
      assign irq_id = id_q;
      assign irq    = irq_q;

      assert_lstat_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (line_stat_ie && |err_flags) |=> irq_id == 4'h6);

      assert_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (!(fifo_en && rx_data_ie) && !(line_stat_ie && |err_flags)) |=> irq_id == 4'h1);

      assert_tie_thresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (rx_en && reached && stale && !lstat_c) |=> irq_id == 4'h4);

      assert_irq_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
         irq == (irq_id != 4'h1));
   end else begin : g_comb_out
      assign irq_id = code_c;
      assign irq    = any_c;
   end

endmodule

// File: tb/tb_uart_rx_irq_ctrl.sv
`timescale 1ns/1ps
module tb_uart_rx_irq_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fifo_en = 1'b0;
   logic       rx_data_ie = 1'b0;
   logic       line_stat_ie = 1'b0;
   logic [4:0] fifo_count = '0;
   logic       rx_push = 1'b0;
   logic       rx_pop = 1'b0;
   logic [3:0] err_flags = '0;
   logic [1:0] trig_sel = '0;
   logic [1:0] data_sel = '0;
   logic       parity_en = 1'b0;
   logic       two_stop = 1'b0;
   logic       baud_tick = 1'b0;
   logic       irq;
   logic [3:0] irq_id;
   logic       data_ready;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   uart_rx_irq_ctrl dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .fifo_en      (fifo_en),
      .rx_data_ie   (rx_data_ie),
      .line_stat_ie (line_stat_ie),
      .fifo_count   (fifo_count),
      .rx_push      (rx_push),
      .rx_pop       (rx_pop),
      .err_flags    (err_flags),
      .trig_sel     (trig_sel),
      .data_sel     (data_sel),
      .parity_en    (parity_en),
      .two_stop     (two_stop),
      .baud_tick    (baud_tick),
      .irq          (irq),
      .irq_id       (irq_id),
      .data_ready   (data_ready)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   task automatic push_one();
      rx_push = 1'b1;
      @(negedge clk);
      rx_push = 1'b0;
      fifo_count = fifo_count + 5'd1;
   endtask

   task automatic pop_one();
      rx_pop = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0;
      fifo_count = fifo_count - 5'd1;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         baud_tick = 1'b1;
         @(negedge clk);
         baud_tick = 1'b0;
      end
   endtask

   function automatic int limit_of(input int d, input int p, input int s);
      return 4 * (1 + 5 + d + p + 1 + s);
   endfunction

   function automatic int level_of(input int sel);
      case (sel)
         0: return 1;
         1: return 4;
         2: return 8;
         default: return 14;
      endcase
   endfunction

   initial begin
      #800000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int lim;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle();
      // R11 reset state
      chk("R11 irq_id", irq_id, 4'h1);
      chk("R11 irq", irq, 0);
      chk("R11 data_ready", data_ready, 0);

      fifo_en = 1'b1;
      rx_data_ie = 1'b1;
      line_stat_ie = 1'b1;
      trig_sel = 2'd3;

      // R5 sweep over every frame shape, with R4 and R8 on each pass
      for (int d = 0; d < 4; d++)
         for (int p = 0; p < 2; p++)
            for (int s = 0; s < 2; s++) begin
               data_sel = 2'(d);
               parity_en = 1'(p);
               two_stop = 1'(s);
               lim = limit_of(d, p, s);
               idle();
               push_one();
               chk("R4 data_ready after push", data_ready, 1);
               ticks(lim - 1);
               idle();
               chk("R5 one tick short", irq_id, 4'h1);
               ticks(1);
               idle();
               chk("R5 stale code at limit", irq_id, 4'hC);
               chk("R10 irq with stale", irq, 1);
               pop_one();
               idle();
               chk("R6 pop clears stale", irq_id, 4'h1);
               chk("R4 data_ready cleared on empty", data_ready, 0);
               ticks(lim + 3);
               idle();
               chk("R8 no stale when empty", irq_id, 4'h1);
            end

      // R7 restart rules, R6 restart after pop
      data_sel = 2'd3; parity_en = 1'b1; two_stop = 1'b1;
      lim = limit_of(3, 1, 1);
      idle();
      push_one();
      ticks(lim - 2);
      push_one();
      ticks(lim - 1);
      idle();
      chk("R7 push restarted timer", irq_id, 4'h1);
      ticks(1);
      idle();
      chk("R7 fires after restart", irq_id, 4'hC);
      push_one();
      idle();
      chk("R7 push keeps fired flag", irq_id, 4'hC);
      pop_one();
      idle();
      chk("R6 pop clears", irq_id, 4'h1);
      ticks(lim - 1);
      idle();
      chk("R6 restarted from zero", irq_id, 4'h1);
      ticks(1);
      idle();
      chk("R6 fires again", irq_id, 4'hC);

      // R1 gating of the stale code
      rx_data_ie = 1'b0;
      idle();
      chk("R1 stale masked by rx enable", irq_id, 4'h1);
      chk("R10 irq low when masked", irq, 0);
      rx_data_ie = 1'b1;
      fifo_en = 1'b0;
      idle();
      chk("R1 stale masked by fifo enable", irq_id, 4'h1);
      fifo_en = 1'b1;
      idle();
      chk("R1 stale back", irq_id, 4'hC);

      // R9 tie: threshold met while stale flag is up
      trig_sel = 2'd0;
      idle();
      chk("R9 threshold over stale", irq_id, 4'h4);

      // R3 line status over everything
      err_flags = 4'b0100;
      idle();
      chk("R3 line status wins", irq_id, 4'h6);
      chk("R10 irq with line status", irq, 1);
      line_stat_ie = 1'b0;
      idle();
      chk("R3 line status disabled", irq_id, 4'h4);
      line_stat_ie = 1'b1;
      err_flags = '0;

      // R8 empty FIFO cancels the flag
      trig_sel = 2'd3;
      fifo_count = '0;
      idle();
      idle();
      chk("R8 empty cancels stale", irq_id, 4'h1);

      // R2 sweep over thresholds and occupancy
      for (int t = 0; t < 4; t++)
         for (int c = 0; c <= 16; c++) begin
            trig_sel = 2'(t);
            fifo_count = 5'(c);
            idle();
            chk($sformatf("R2 sel %0d count %0d", t, c), irq_id,
                (c >= level_of(t)) ? 4'h4 : 4'h1);
            chk("R10 irq follows code", irq, (c >= level_of(t)) ? 1 : 0);
         end

      // R1 gating of the threshold code, with line status still honoured
      fifo_count = 5'd16;
      fifo_en = 1'b0;
      idle();
      chk("R1 threshold masked", irq_id, 4'h1);
      err_flags = 4'b0001;
      idle();
      chk("R3 line status without fifo enable", irq_id, 4'h6);
      err_flags = '0;
      fifo_en = 1'b1;
      fifo_count = '0;
      idle();
      idle();
      chk("R2 empty below threshold", irq_id, 4'h1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule